// File: doc/BRIEF.md
# Digital PID Loop Compensator

This block is the discrete-time compensator of a digitally controlled switching regulator. Once per voltage-ADC sample it takes a signed error code (target minus digitized output, one code being one ADC step of 3.125 mV) and produces a duty command for the pulse-width modulator. The ADC runs synchronously with switching at twice the phase count times the switching frequency, and so does this loop.

The error feeds four parallel terms: a saturating integrator, a proportional gain, a gain on the first backward difference and a gain on the second backward difference. Their sum passes through a two-pole all-pole low-pass recursion. A maximum-duty factor then scales the filtered value, and the result is clamped to a programmable ceiling. Software loads every gain and limit through a simple write port. The write port and the sample strobe act independently, so either may arrive in any cycle.

Top module: `pid_loop_comp`

## Requirements
- R1: While rst_n is low, out_duty is 0 and out_valid is 0. Reset also clears every coefficient and limit register, the error history, the integrator and both filter state words.
- R2: When in_valid is high at clock edge k, out_valid is high for exactly the cycle that follows edge k+1. out_duty changes only at that edge and holds its value at all other times.
- R3: Gains are 16-bit signed with 8 fractional bits. The pre-filter value is u = floor(S/256), where S is the integrator value plus kp·e plus the three other term products.
- R4: On each sample the integrator becomes clamp(I + ki·e, −ilim, +ilim) and then enters S. ilim is a 31-bit unsigned value on the same scale as I. The integrator saturates and does not wrap.
- R5: The first-difference term is kd·(e[n] − e[n−1]).
- R6: The second-difference term is kd2·(e[n] − 2·e[n−1] + e[n−2]).
- R7: The filter output is y[n] = clamp(u + floor((a1·y[n−1] + a2·y[n−2])/256), −2^23, 2^23−1). a1 and a2 are 16-bit signed values with 8 fractional bits.
- R8: The scaled value is floor(y·kmod/256). kmod is 16-bit unsigned with 8 fractional bits.
- R9: out_duty is the scaled value clamped to the range 0 to dmax, where dmax is a 12-bit unsigned value.
- R10: A write takes cfg_wdata into the register at cfg_addr, using its low bits: 0 kp, 1 ki, 2 kd, 3 kd2, 4 a1, 5 a2, 6 kmod, 7 ilim, 8 dmax. If a gain write lands in the same cycle as in_valid, that sample still uses the old value and the new value applies from the next sample.
- R11: While in_valid is low, in_err is ignored. The error history, the integrator and the filter state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient register select |
| cfg_wdata | input | 31 | Coefficient write data |
| in_valid | input | 1 | Error sample strobe |
| in_err | input | 12 | Signed error in ADC codes |
| out_valid | output | 1 | Duty command update pulse |
| out_duty | output | 12 | Duty command |

## Verification
A coefficient write and a sample strobe can land on the same clock edge. In that case the sample must see the gain as it was before the write. The bench provokes this by asserting cfg_we on kp together with in_valid. It then judges two outputs: the first must reflect the old gain and the following sample the new one. Apart from that collision, back-to-back history effects (derivative, filter and integrator saturation) are judged against an arithmetic model built from the requirements.

// File: rtl/pid_loop_comp.sv
module pid_loop_comp #(
  parameter int EW   = 12,
  parameter int CW   = 16,
  parameter int FRAC = 8,
  parameter int LIMW = 31,
  parameter int YW   = 24,
  parameter int OW   = 12,
  parameter int AW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [LIMW-1:0]      cfg_wdata,
  input  logic                 in_valid,
  input  logic signed [EW-1:0] in_err,
  output logic                 out_valid,
  output logic [OW-1:0]        out_duty
);
  localparam int LW = 48;

  logic signed [CW-1:0] kp, ki, kd, kd2, a1, a2;
  logic [CW-1:0]        kmod;
  logic [LIMW-1:0]      ilim;
  logic [OW-1:0]        dmax;

  logic signed [EW-1:0] e1, e2;
  logic signed [LW-1:0] acc, y1, y2, ys;
  logic                 s1;

  logic signed [LW-1:0] ex, e1x, e2x, ilx, kmx, ymax;
  logic signed [LW-1:0] acc_n, sum, u, fb, y_n, z, out_n;

  function automatic logic signed [LW-1:0] clamp(input logic signed [LW-1:0] v,
                                                 input logic signed [LW-1:0] lo,
                                                 input logic signed [LW-1:0] hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kp <= '0; ki <= '0; kd <= '0; kd2 <= '0;
      a1 <= '0; a2 <= '0; kmod <= '0; ilim <= '0; dmax <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        AW'(0): kp   <= cfg_wdata[CW-1:0];
        AW'(1): ki   <= cfg_wdata[CW-1:0];
        AW'(2): kd   <= cfg_wdata[CW-1:0];
        AW'(3): kd2  <= cfg_wdata[CW-1:0];
        AW'(4): a1   <= cfg_wdata[CW-1:0];
        AW'(5): a2   <= cfg_wdata[CW-1:0];
        AW'(6): kmod <= cfg_wdata[CW-1:0];
        AW'(7): ilim <= cfg_wdata;
        AW'(8): dmax <= cfg_wdata[OW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    ex    = LW'(in_err);
    e1x   = LW'(e1);
    e2x   = LW'(e2);
    ilx   = LW'(ilim);
    kmx   = LW'(kmod);
    ymax  = LW'({(YW-1){1'b1}});
    acc_n = clamp(acc + LW'(ki) * ex, -ilx, ilx);
    sum   = acc_n + LW'(kp) * ex + LW'(kd) * (ex - e1x)
          + LW'(kd2) * (ex - (e1x <<< 1) + e2x);
    u     = sum >>> FRAC;
    fb    = (LW'(a1) * y1 + LW'(a2) * y2) >>> FRAC;
    y_n   = clamp(u + fb, -ymax - 1, ymax);
    z     = (ys * kmx) >>> FRAC;
    out_n = clamp(z, '0, LW'(dmax));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; y1 <= '0; y2 <= '0; ys <= '0;
      e1 <= '0; e2 <= '0;
      s1 <= 1'b0; out_valid <= 1'b0; out_duty <= '0;
    end else begin
      s1        <= in_valid;
      out_valid <= s1;
      if (in_valid) begin
        acc <= acc_n;
        e1  <= in_err;
        e2  <= e1;
        y1  <= y_n;
        y2  <= y1;
        ys  <= y_n;
      end
      if (s1) out_duty <= OW'(out_n);
    end
  end

  p_lat_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid, 2) |-> out_valid);
  p_lat_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_duty));
  p_acc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |-> (acc <= $past(ilx) && acc >= -$past(ilx)));
  p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |-> (e2 == $past(e1) && e1 == $past(in_err)));
  p_duty_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_duty <= $past(dmax));
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(acc) && $stable(e1) && $stable(e2)
                          && $stable(y1) && $stable(y2)));
endmodule

// File: tb/pid_loop_comp_tb_top.sv
`timescale 1ns/1ps
module pid_loop_comp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [30:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic signed [11:0] in_err = '0;
  logic out_valid;
  logic [11:0] out_duty;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam longint YMX = (64'sd1 <<< 23) - 1;
  localparam int PT [6][2] = '{'{100, 200}, '{5, 10}, '{0, 0}, '{-3, 0},
                               '{1000, 2000}, '{2047, 4000}};

  longint m_kp, m_ki, m_kd, m_kd2, m_a1, m_a2, m_km, m_il, m_dm;
  longint m_acc, m_e1, m_e2, m_y1, m_y2;

  pid_loop_comp dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_err(in_err),
    .out_valid(out_valid), .out_duty(out_duty)
  );

  always #10 clk = ~clk;

  function automatic longint sat(input longint v, input longint lo, input longint hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic longint s16(input int d);
    logic signed [15:0] t;
    t = d[15:0];
    return longint'(t);
  endfunction

  function automatic void mwrite(input int a, input int d);
    case (a)
      0: m_kp  = s16(d);
      1: m_ki  = s16(d);
      2: m_kd  = s16(d);
      3: m_kd2 = s16(d);
      4: m_a1  = s16(d);
      5: m_a2  = s16(d);
      6: m_km  = longint'(d & 32'hFFFF);
      7: m_il  = longint'(d & 32'h7FFF_FFFF);
      8: m_dm  = longint'(d & 32'hFFF);
      default: ;
    endcase
  endfunction

  function automatic longint model(input int e);
    longint ee, ac, s, u, y, z;
    ee = longint'(e);
    ac = sat(m_acc + m_ki * ee, -m_il, m_il);
    s  = ac + m_kp * ee + m_kd * (ee - m_e1) + m_kd2 * (ee - 2 * m_e1 + m_e2);
    u  = s >>> 8;
    y  = sat(u + ((m_a1 * m_y1 + m_a2 * m_y2) >>> 8), -YMX - 1, YMX);
    m_acc = ac; m_e2 = m_e1; m_e1 = ee; m_y2 = m_y1; m_y1 = y;
    z = (y * m_km) >>> 8;
    return sat(z, 0, m_dm);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0; cfg_we = 1'b0;
    m_kp = 0; m_ki = 0; m_kd = 0; m_kd2 = 0; m_a1 = 0; m_a2 = 0;
    m_km = 0; m_il = 0; m_dm = 0;
    m_acc = 0; m_e1 = 0; m_e2 = 0; m_y1 = 0; m_y2 = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 31'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    mwrite(a, d);
  endtask

  task automatic base_cfg(input int kp);
    wr(0, kp); wr(6, 256); wr(7, 32'h7FFF_FFFF); wr(8, 4000);
  endtask

  task automatic sample(input int e, input string req, input bit w, input int wa,
                        input int wd, output longint act, output longint exp);
    @(negedge clk);
    in_valid = 1'b1; in_err = 12'(e);
    cfg_we = w; cfg_addr = 4'(wa); cfg_wdata = 31'(wd);
    exp = model(e);
    if (w) mwrite(wa, wd);
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    chk(req, longint'(out_valid), 1);
    act = longint'(out_duty);
  endtask

  task automatic smp(input int e, input string req);
    longint a, x;
    sample(e, req, 1'b0, 0, 0, a, x);
    chk(req, a, x);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL R2 watchdog expired actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    longint a, x;
    do_reset();
    @(negedge clk);
    chk("R1 valid after reset", longint'(out_valid), 0);
    chk("R1 duty after reset", longint'(out_duty), 0);

    // R2 timing and hold
    base_cfg(512);
    @(negedge clk);
    in_valid = 1'b1; in_err = 12'sd50;
    x = model(50);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 valid early", longint'(out_valid), 0);
    chk("R2 duty held", longint'(out_duty), 0);
    @(negedge clk);
    chk("R2 valid pulse", longint'(out_valid), 1);
    chk("R2 duty value", longint'(out_duty), x);
    @(negedge clk);
    chk("R2 valid single", longint'(out_valid), 0);
    chk("R2 duty hold after", longint'(out_duty), 100);

    // R3 / R9 vector table
    for (int i = 0; i < 6; i++) begin
      sample(PT[i][0], "R3 R9 table", 1'b0, 0, 0, a, x);
      chk("R3 R9 table", a, longint'(PT[i][1]));
    end

    // R8 scaling
    wr(6, 128);
    smp(100, "R8 kmod half");
    wr(6, 384);
    smp(100, "R8 kmod 1.5");

    // R4 integrator saturation
    do_reset();
    wr(0, 0); wr(1, 256); wr(6, 256); wr(7, 128000); wr(8, 4000);
    for (int i = 0; i < 4; i++) smp(200, "R4 integrate up");
    for (int i = 0; i < 3; i++) smp(-2047, "R4 integrate down");
    smp(1000, "R4 recover from floor");

    // R5 first difference
    do_reset();
    base_cfg(0); wr(2, 256);
    smp(0, "R5 diff"); smp(100, "R5 diff"); smp(300, "R5 diff"); smp(250, "R5 diff neg");

    // R11 idle: inputs ignored, output held
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_err = 12'(i * 97 - 300);
      chk("R11 idle hold", longint'(out_duty), 0);
    end
    smp(400, "R11 history kept");

    // R6 second difference
    do_reset();
    base_cfg(0); wr(3, 256);
    smp(0, "R6 diff2"); smp(100, "R6 diff2"); smp(300, "R6 diff2"); smp(700, "R6 diff2");

    // R7 filter a1 then a2
    do_reset();
    base_cfg(256); wr(4, 128);
    smp(400, "R7 a1"); smp(0, "R7 a1"); smp(0, "R7 a1"); smp(0, "R7 a1");
    do_reset();
    base_cfg(256); wr(5, 64);
    smp(400, "R7 a2"); smp(0, "R7 a2"); smp(0, "R7 a2");

    // R7 filter saturation
    do_reset();
    base_cfg(32767); wr(4, 512); wr(6, 1); wr(8, 4095);
    for (int i = 0; i < 6; i++) smp(2047, "R7 grow");
    wr(0, 0); wr(4, 128);
    for (int i = 0; i < 7; i++) smp(0, "R7 decay from rail");

    // R10 write colliding with a sample
    do_reset();
    base_cfg(512);
    sample(100, "R10 collision old gain", 1'b1, 0, 256, a, x);
    chk("R10 collision old gain", a, 200);
    smp(100, "R10 new gain next sample");

    // R1 reset mid-run clears state and coefficients
    do_reset();
    @(negedge clk);
    chk("R1 duty after mid reset", longint'(out_duty), 0);
    smp(500, "R1 zero coefficients");
    base_cfg(0); wr(2, 256);
    smp(100, "R1 history cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule